// File: doc/BRIEF.md
# PRG ROM Upper Address Extension

This block sits next to a bank-switching mapper on a cartridge bus and watches the CPU's writes to the mapper's bank-select and bank-data registers. From those writes it keeps a private copy of the program-bank layout mode and of one extra bank bit for each of the two switchable program banks. From these it drives one additional high address line into program ROM. That line doubles the reachable program space from 64 to 128 banks of 8 KB, which is 1 MB.

For every access with A15 high, the 8 KB window that the CPU addresses decides where the line comes from. It can come from the first switchable bank's stored bit, from the second switchable bank's stored bit, or it can be forced to 1. Forcing it to 1 places the fixed banks at the top of the enlarged space. The mapper keeps driving the lower bank bits itself. This block only snoops the bus and adds nothing to the handshake.

The CPU bus timing is sampled by a local clock. A register write counts when the sampled bus-phase strobe falls.

Top module: `prg_a19_ext`

## Requirements
- R1: After reset the layout mode is 0 and both extra bits are 0. Reads at $8000 and $A000 then give 0, and reads at $C000 and $E000 give 1.
- R2: A write to an even address in $8000–$9FFF (A0=0) stores data bits 2:0 as the register index and data bit 6 as the layout mode.
- R3: A write to an odd address in $8000–$9FFF (A0=1) stores data bit 6 as the first extra bit when the index is 6, and as the second extra bit when the index is 7.
- R4: An odd-address write while the index is 0 to 5 leaves both extra bits unchanged.
- R5: In mode 0 the output equals the first extra bit for $8000–$9FFF and is 1 for $C000–$DFFF.
- R6: In mode 1 the output equals the first extra bit for $C000–$DFFF and is 1 for $8000–$9FFF.
- R7: For $A000–$BFFF the output equals the second extra bit in either mode.
- R8: For $E000–$FFFF the output is always 1.
- R9: When A15 is 0 the output is 0.
- R10: The block accepts a write only on a falling edge of the sampled strobe, with rw_i=0 and address bits 15:13 equal to 100. A read cycle, a strobe that does not fall, and a write to $A000–$FFFF all leave the mode, the index and both extra bits unchanged.
- R11: A stored value takes effect on the output from the clock edge that samples the strobe low after it was high. The output follows the address lines with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the bus signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_phase_i | input | 1 | CPU bus-phase strobe; a falling edge ends a cycle |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_hi_i | input | 3 | CPU address bits 15:13 |
| addr_lsb_i | input | 1 | CPU address bit 0 |
| data_i | input | 8 | CPU data bus |
| rom_a19_o | output | 1 | Extra program ROM address line |

## Verification
The output is combinational from the address lines and the stored state. Every read check therefore sets the address at a falling clock edge and samples 1 ns later, with no clock edge in between. A register write takes effect at the first rising clock edge that sees the strobe low after it was high, and the bench raises the strobe one clock earlier. The write task returns one falling edge after that capture edge, so each read that follows observes the updated state. Ignored writes are checked by reading back every affected window right after the ignored cycle.

// File: rtl/prg_ext_pkg.sv
package prg_ext_pkg;

  // Address bits 15:13 select one of four 8 KB windows when A15 is high.
  typedef enum logic [1:0] {
    WIN_LO  = 2'd0,   // $8000-$9FFF
    WIN_MID = 2'd1,   // $A000-$BFFF
    WIN_HI  = 2'd2,   // $C000-$DFFF
    WIN_TOP = 2'd3    // $E000-$FFFF
  } prg_win_e;

  localparam int ADDR_HI_W = 3;
  localparam int EXT_CNT   = 2;   // two switchable program banks

  function automatic prg_win_e win_of(input logic [ADDR_HI_W-1:0] hi);
    return prg_win_e'(hi[1:0]);
  endfunction

endpackage

// File: rtl/prg_ext_wr_snoop.sv
module prg_ext_wr_snoop
  import prg_ext_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_phase_i,
  input  logic                 rw_i,
  input  logic [ADDR_HI_W-1:0] addr_hi_i,
  input  logic                 addr_lsb_i,
  output logic                 sel_we_o,
  output logic                 dat_we_o
);

  logic phase_q;
  logic phase_fall;
  logic reg_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= bus_phase_i;
  end

  assign phase_fall = phase_q & ~bus_phase_i;
  // only the $8000-$9FFF register pair is shadowed
  assign reg_hit    = phase_fall & ~rw_i &
                      addr_hi_i[ADDR_HI_W-1] & (win_of(addr_hi_i) == WIN_LO);
  assign sel_we_o   = reg_hit & ~addr_lsb_i;
  assign dat_we_o   = reg_hit &  addr_lsb_i;

  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we_o || dat_we_o) |-> (!rw_i && $past(bus_phase_i) && !bus_phase_i)); // R10

endmodule

// File: rtl/prg_ext_shadow.sv
module prg_ext_shadow
  import prg_ext_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3,
  parameter int MODE_POS = 6,
  parameter int EXT_POS  = 6,
  parameter int EXT_BASE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we_i,
  input  logic              dat_we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mode_o,
  output logic [EXT_CNT-1:0] ext_o
);

  logic [IDX_W-1:0]   idx_q;
  logic               mode_q;
  logic [EXT_CNT-1:0] ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mode_q <= 1'b0;
    end else if (sel_we_i) begin
      idx_q  <= data_i[IDX_W-1:0];
      mode_q <= data_i[MODE_POS];
    end
  end

  for (genvar k = 0; k < EXT_CNT; k++) begin : g_ext
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(EXT_BASE + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ext_q[k] <= 1'b0;
      else if (dat_we_i && idx_q == MY_IDX)  ext_q[k] <= data_i[EXT_POS];
    end
  end

  assign mode_o = mode_q;
  assign ext_o  = ext_q;

  AST_MODE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we_i |=> (mode_q == $past(data_i[MODE_POS]))); // R2
  AST_FIRST_EXT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we_i && idx_q == IDX_W'(EXT_BASE)) |=> (ext_q[0] == $past(data_i[EXT_POS]))); // R3
  AST_SECOND_EXT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we_i && idx_q == IDX_W'(EXT_BASE + 1)) |=> (ext_q[1] == $past(data_i[EXT_POS]))); // R3
  AST_LOW_INDEX_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we_i && idx_q < IDX_W'(EXT_BASE)) |=> $stable(ext_q)); // R4
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_we_i && !dat_we_i) |=> ($stable(ext_q) && $stable(mode_q) && $stable(idx_q))); // R10

endmodule

// File: rtl/prg_ext_window_mux.sv
module prg_ext_window_mux
  import prg_ext_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_HI_W-1:0] addr_hi_i,
  input  logic                 mode_i,
  input  logic [EXT_CNT-1:0]   ext_i,
  output logic                 a19_o
);

  prg_win_e win;
  logic     in_rom;

  assign win    = win_of(addr_hi_i);
  assign in_rom = addr_hi_i[ADDR_HI_W-1];

  always_comb begin
    a19_o = 1'b0;
    if (in_rom) begin
      unique case (win)
        WIN_LO:  a19_o = mode_i ? 1'b1 : ext_i[0];
        WIN_MID: a19_o = ext_i[1];
        WIN_HI:  a19_o = mode_i ? ext_i[0] : 1'b1;
        WIN_TOP: a19_o = 1'b1;
        default: a19_o = 1'b0;
      endcase
    end
  end

  AST_MODE0_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && addr_hi_i == 3'b100) |-> (a19_o == ext_i[0])); // R5
  AST_MODE0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && addr_hi_i == 3'b110) |-> a19_o); // R5
  AST_MODE1_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && addr_hi_i == 3'b110) |-> (a19_o == ext_i[0])); // R6
  AST_MODE1_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && addr_hi_i == 3'b100) |-> a19_o); // R6
  AST_MID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi_i == 3'b101) |-> (a19_o == ext_i[1])); // R7
  AST_TOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi_i == 3'b111) |-> a19_o); // R8
  AST_LOW_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hi_i[ADDR_HI_W-1] |-> !a19_o); // R9

endmodule

// File: rtl/prg_a19_ext.sv
module prg_a19_ext
  import prg_ext_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3,
  parameter int MODE_POS = 6,
  parameter int EXT_POS  = 6,
  parameter int EXT_BASE = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_phase_i,
  input  logic                 rw_i,
  input  logic [ADDR_HI_W-1:0] addr_hi_i,
  input  logic                 addr_lsb_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic                 rom_a19_o
);

  logic               sel_we;
  logic               dat_we;
  logic               mode;
  logic [EXT_CNT-1:0] ext;

  prg_ext_wr_snoop i_snoop (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_phase_i(bus_phase_i),
    .rw_i       (rw_i),
    .addr_hi_i  (addr_hi_i),
    .addr_lsb_i (addr_lsb_i),
    .sel_we_o   (sel_we),
    .dat_we_o   (dat_we)
  );

  prg_ext_shadow #(
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .MODE_POS(MODE_POS),
    .EXT_POS (EXT_POS),
    .EXT_BASE(EXT_BASE)
  ) i_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_we_i(sel_we),
    .dat_we_i(dat_we),
    .data_i  (data_i),
    .mode_o  (mode),
    .ext_o   (ext)
  );

  prg_ext_window_mux i_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_hi_i(addr_hi_i),
    .mode_i   (mode),
    .ext_i    (ext),
    .a19_o    (rom_a19_o)
  );

endmodule

// File: tb/test_prg_a19_ext.sv
module test_prg_a19_ext;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 34;

  // {is_write, addr[15:0], data[7:0], expected, requirement number}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 16'h8000, 8'h06, 1'b0, 4'd2},   // select first bank, mode 0
    {1'b1, 16'h8001, 8'h00, 1'b0, 4'd3},
    {1'b0, 16'h8000, 8'h00, 1'b0, 4'd5},   // R5
    {1'b1, 16'h8001, 8'h40, 1'b0, 4'd3},
    {1'b0, 16'h8000, 8'h00, 1'b1, 4'd5},   // R5 / R3
    {1'b0, 16'hC000, 8'h00, 1'b1, 4'd5},   // R5 fixed window
    {1'b1, 16'h8000, 8'h07, 1'b0, 4'd2},
    {1'b1, 16'h8001, 8'h00, 1'b0, 4'd3},
    {1'b0, 16'hA000, 8'h00, 1'b0, 4'd7},   // R7
    {1'b1, 16'h8001, 8'h40, 1'b0, 4'd3},
    {1'b0, 16'hA000, 8'h00, 1'b1, 4'd7},   // R7
    {1'b0, 16'h9FFF, 8'h00, 1'b1, 4'd3},   // R3 first bit kept
    {1'b1, 16'h8000, 8'h46, 1'b0, 4'd2},   // mode 1
    {1'b0, 16'h8000, 8'h00, 1'b1, 4'd6},   // R6 fixed window
    {1'b0, 16'hC000, 8'h00, 1'b1, 4'd6},   // R6
    {1'b1, 16'h8001, 8'h00, 1'b0, 4'd3},
    {1'b0, 16'hC000, 8'h00, 1'b0, 4'd6},   // R6
    {1'b0, 16'h8000, 8'h00, 1'b1, 4'd6},   // R6
    {1'b0, 16'hA000, 8'h00, 1'b1, 4'd7},   // R7 in mode 1
    {1'b0, 16'hE000, 8'h00, 1'b1, 4'd8},   // R8
    {1'b0, 16'hFFFF, 8'h00, 1'b1, 4'd8},   // R8
    {1'b1, 16'h8000, 8'h47, 1'b0, 4'd2},
    {1'b1, 16'h8001, 8'h00, 1'b0, 4'd3},
    {1'b0, 16'hBFFF, 8'h00, 1'b0, 4'd7},   // R7
    {1'b0, 16'hDFFF, 8'h00, 1'b0, 4'd6},   // R6
    {1'b1, 16'h8000, 8'h03, 1'b0, 4'd2},   // index 3, mode 0
    {1'b1, 16'h8001, 8'h40, 1'b0, 4'd4},
    {1'b0, 16'h8000, 8'h00, 1'b0, 4'd4},   // R4 first bit untouched
    {1'b0, 16'hA000, 8'h00, 1'b0, 4'd4},   // R4 second bit untouched
    {1'b1, 16'h8000, 8'h06, 1'b0, 4'd2},
    {1'b1, 16'hC001, 8'h40, 1'b0, 4'd10},  // outside register window
    {1'b1, 16'hE000, 8'h46, 1'b0, 4'd10},
    {1'b0, 16'h8000, 8'h00, 1'b0, 4'd10},  // R10 both ignored
    {1'b0, 16'h7FFF, 8'h00, 1'b0, 4'd9}    // R9
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_phase = 1'b0;
  logic       rw = 1'b1;
  logic [2:0] addr_hi = 3'b000;
  logic       addr_lsb = 1'b0;
  logic [7:0] data = 8'h00;
  logic       rom_a19;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_a19_ext i_prg_a19_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_phase_i(bus_phase),
    .rw_i       (rw),
    .addr_hi_i  (addr_hi),
    .addr_lsb_i (addr_lsb),
    .data_i     (data),
    .rom_a19_o  (rom_a19)
  );

  task automatic set_addr(input logic [15:0] a);
    addr_hi  = a[15:13];
    addr_lsb = a[0];
  endtask

  // strobe high for one clock, then low: captured at the following rising edge
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic is_rd);
    @(negedge clk);
    set_addr(a);
    data = d;
    rw = is_rd;
    bus_phase = 1'b1;
    @(negedge clk);
    bus_phase = 1'b0;
    @(negedge clk);
    rw = 1'b1;
  endtask

  task automatic check_read(input logic [15:0] a, input logic exp, input int req);
    @(negedge clk);
    set_addr(a);
    #1ns;
    n_checks++;
    if (rom_a19 !== exp) begin
      n_fail++;
      $display("FAIL R%0d addr=%h actual=%b expected=%b", req, a, rom_a19, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R0 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_read(16'h8000, 1'b0, 1);
    check_read(16'hA000, 1'b0, 1);
    check_read(16'hC000, 1'b1, 1);
    check_read(16'hE000, 1'b1, 1);
    check_read(16'h0000, 1'b0, 9);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][29]) bus_cycle(VEC[i][28:13], VEC[i][12:5], 1'b0);
      else            check_read(VEC[i][28:13], VEC[i][4], int'(VEC[i][3:0]));
    end

    // R10: a read cycle that falls on the select register changes nothing
    bus_cycle(16'h8000, 8'h46, 1'b1);
    check_read(16'h8000, 1'b0, 10);
    check_read(16'hC000, 1'b1, 10);

    // R10: strobe held high (no falling edge) during a write
    @(negedge clk);
    set_addr(16'h8000); data = 8'h46; rw = 1'b0; bus_phase = 1'b1;
    repeat (3) @(negedge clk);
    rw = 1'b1;
    check_read(16'h8000, 1'b0, 10);
    bus_phase = 1'b0;

    // R11: the new value is visible from the capture edge on
    @(negedge clk);
    set_addr(16'h8000); data = 8'h46; rw = 1'b0; bus_phase = 1'b1;
    @(negedge clk);
    bus_phase = 1'b0;
    #1ns;
    n_checks++;
    if (rom_a19 !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 before capture actual=%b expected=0", rom_a19);
    end
    @(posedge clk);
    #1ns;
    n_checks++;
    if (rom_a19 !== 1'b1) begin
      n_fail++;
      $display("FAIL R11 after capture actual=%b expected=1", rom_a19);
    end
    rw = 1'b1;

    // R1: reset in mid-run clears mode and both extra bits
    bus_cycle(16'h8001, 8'h40, 1'b0);   // first bit set, mode 1
    bus_cycle(16'h8000, 8'h47, 1'b0);
    bus_cycle(16'h8001, 8'h40, 1'b0);
    check_read(16'hA000, 1'b1, 7);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_read(16'h8000, 1'b0, 1);
    check_read(16'hA000, 1'b0, 1);
    check_read(16'hC000, 1'b1, 1);
    check_read(16'h6000, 1'b0, 9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule